// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. Each frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit. The transmit path has two stages. A one-entry holding register accepts a byte from the host. A shift stage takes that byte as soon as it is free and drives it onto the line. Because of this the host can queue the next byte while the current one is still going out, and consecutive frames leave with no idle gap between them.

Bit timing comes from a 12-bit divisor. In normal mode one bit lasts 16 × (divisor + 1) clock cycles. In double-speed mode it lasts 8 × (divisor + 1) cycles. Two status flags tell the host what to do next. One reports that the holding register has room for a byte. The other reports that all queued data has fully left the line. Each flag has its own interrupt output, gated by its own enable. When the transmit enable is low, the pin shows a general-purpose output value instead of the serial line.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `buf_empty` is 1, `tx_done` is 0, and `tx_pin` is high while `tx_en` is 1.
- R2: A frame on `tx_pin` is a low start bit, then `wr_data[0]` through `wr_data[7]` in that order, then a high stop bit. The line is high whenever no frame is in progress.
- R3: With `dbl_speed` at 0, every bit of a frame lasts exactly 16 × (`divisor` + 1) clock cycles.
- R4: With `dbl_speed` at 1, every bit of a frame lasts exactly 8 × (`divisor` + 1) clock cycles.
- R5: A write (`wr_valid` high at a rising edge) is accepted only while `buf_empty` is 1. `buf_empty` reads 0 after that edge. If the shift stage is idle, the byte moves into it at the next edge: the start bit begins there and `buf_empty` returns to 1.
- R6: A write made while `buf_empty` is 0 is ignored. It changes no flag and its byte is never transmitted.
- R7: A byte waiting in the holding register starts its start bit at the same edge that ends the previous stop bit. `tx_done` stays 0 between the two frames.
- R8: `tx_done` becomes 1 at the edge that ends a stop bit when no byte is waiting. It then stays 1.
- R9: `tx_done` is cleared by an accepted write or by a `done_clr` pulse. It reads 0 after that edge.
- R10: While `tx_en` is 0, `tx_pin` equals `gpo_value`, including while a frame is in progress.
- R11: `irq_empty` equals `buf_empty` AND `irq_empty_en`, and `irq_done` equals `tx_done` AND `irq_done_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Gives the pin to the serial line when 1 |
| dbl_speed | input | 1 | Selects 8 instead of 16 clock groups per bit |
| divisor | input | 12 | Baud divisor, 0 to 4095 |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to transmit |
| done_clr | input | 1 | Clears `tx_done` |
| gpo_value | input | 1 | Pin value while transmit is disabled |
| irq_empty_en | input | 1 | Enables `irq_empty` |
| irq_done_en | input | 1 | Enables `irq_done` |
| tx_pin | output | 1 | Serial output pin |
| buf_empty | output | 1 | Holding register can take a byte |
| tx_done | output | 1 | All queued data has been shifted out |
| irq_empty | output | 1 | Room-in-buffer interrupt |
| irq_done | output | 1 | Transmission-complete interrupt |

## Verification
Let a write be captured at edge k and let B be the bit length in cycles. Then `buf_empty` is 0 right after edge k, and the start bit with `buf_empty` back at 1 appears after edge k+1. Bit i is driven from edge k+1+i·B up to edge k+1+(i+1)·B. `tx_done` rises exactly at edge k+1+10·B. The bench drives inputs and samples outputs on falling edges. It counts rising edges from the write to each point, checks the middle of every bit, and checks both sides of the edges that end the start bit and the stop bit. The interrupt and pin-select results are combinational, so they are checked half a cycle after their inputs change.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   // clock groups per bit in each speed mode
   localparam int unsigned OVS_NORMAL = 16;
   localparam int unsigned OVS_DOUBLE = 8;
   // width of the in-bit group counter, sized for the slower mode
   localparam int unsigned OVS_W      = $clog2(OVS_NORMAL);
   // framing bits around the data field: start + stop
   localparam int unsigned FRAME_XTRA = 2;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
   parameter int unsigned DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = (cnt_q == divisor);
   assign tick = run && wrap;

   // counter is held at zero while idle so the first bit starts aligned
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run)    cnt_q <= '0;
      else if (wrap)    cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              done_clr,
   input  logic              load,
   input  logic              frame_end,
   output logic              hold_full,
   output logic [DATA_W-1:0] hold_data,
   output logic              tx_done
);
   logic wr_acc;

   assign wr_acc = wr_valid && !hold_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
      end else if (load) begin
         hold_full <= 1'b0;
      end else if (wr_acc) begin
         hold_full <= 1'b1;
         hold_data <= wr_data;
      end
   end

   // set has priority over the clear strobe; an accepted write clears
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   tx_done <= 1'b0;
      else if (frame_end && !hold_full && !wr_acc)  tx_done <= 1'b1;
      else if (wr_acc || done_clr)                  tx_done <= 1'b0;
   end

   assert_full_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_full && !load && wr_valid) |=> (hold_full && $stable(hold_data)));

   assert_empty_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !hold_full);

   assert_done_only_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> !hold_full);
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
   import uart_tx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter bit          DBL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbl_speed,
   input  logic              tick,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   output logic              load,
   output logic              frame_end,
   output logic              busy,
   output logic              line
);
   localparam int unsigned FRAME_W  = DATA_W + FRAME_XTRA;
   localparam int unsigned IDX_W    = $clog2(FRAME_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

   logic [FRAME_W-1:0] frame_q;
   logic [IDX_W-1:0]   bit_idx;
   logic [OVS_W-1:0]   sub_q;
   logic [OVS_W-1:0]   sub_last;
   logic               bit_end;

   generate
      if (DBL_EN) begin : g_dbl
         assign sub_last = dbl_speed ? OVS_W'(OVS_DOUBLE - 1) : OVS_W'(OVS_NORMAL - 1);
      end else begin : g_single
         logic unused_dbl;
         assign unused_dbl = dbl_speed;
         assign sub_last   = OVS_W'(OVS_NORMAL - 1);
      end
   endgenerate

   assign bit_end   = busy && tick && (sub_q == sub_last);
   assign frame_end = bit_end && (bit_idx == LAST_IDX);
   assign load      = hold_full && (!busy || frame_end);
   assign line      = busy ? frame_q[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         frame_q <= '1;
         bit_idx <= '0;
         sub_q   <= '0;
      end else if (load) begin
         busy    <= 1'b1;
         frame_q <= {1'b1, hold_data, 1'b0};
         bit_idx <= '0;
         sub_q   <= '0;
      end else if (busy && tick) begin
         if (sub_q == sub_last) begin
            sub_q <= '0;
            if (bit_idx == LAST_IDX) begin
               busy <= 1'b0;
            end else begin
               bit_idx <= bit_idx + 1'b1;
               frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
            end
         end else begin
            sub_q <= sub_q + 1'b1;
         end
      end
   end

   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !line);

   assert_tick_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> busy);
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
   parameter int unsigned DIV_W  = 12,
   parameter int unsigned DATA_W = 8,
   parameter bit          DBL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              dbl_speed,
   input  logic [DIV_W-1:0]  divisor,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              done_clr,
   input  logic              gpo_value,
   input  logic              irq_empty_en,
   input  logic              irq_done_en,
   output logic              tx_pin,
   output logic              buf_empty,
   output logic              tx_done,
   output logic              irq_empty,
   output logic              irq_done
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("uart_tx_dbuf: DIV_W must be 1..16");
      end
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_data
         $error("uart_tx_dbuf: DATA_W must be 5..9");
      end
   endgenerate

   logic              tick;
   logic              busy;
   logic              line;
   logic              load;
   logic              frame_end;
   logic              hold_full;
   logic [DATA_W-1:0] hold_data;

   uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .divisor (divisor),
      .tick    (tick)
   );

   uart_tx_holdbuf #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (wr_valid),
      .wr_data   (wr_data),
      .done_clr  (done_clr),
      .load      (load),
      .frame_end (frame_end),
      .hold_full (hold_full),
      .hold_data (hold_data),
      .tx_done   (tx_done)
   );

   uart_tx_shifter #(.DATA_W(DATA_W), .DBL_EN(DBL_EN)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .dbl_speed (dbl_speed),
      .tick      (tick),
      .hold_full (hold_full),
      .hold_data (hold_data),
      .load      (load),
      .frame_end (frame_end),
      .busy      (busy),
      .line      (line)
   );

   assign buf_empty = !hold_full;
   assign tx_pin    = tx_en ? line : gpo_value;
   assign irq_empty = buf_empty && irq_empty_en;
   assign irq_done  = tx_done && irq_done_en;

   assert_load_when_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (!busy || frame_end));
endmodule

// File: tb/test_uart_tx_dbuf.sv
module test_uart_tx_dbuf;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b1;
   logic       dbl_speed = 1'b0;
   logic [11:0] divisor = 12'd1;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       done_clr = 1'b0;
   logic       gpo_value = 1'b0;
   logic       irq_empty_en = 1'b0;
   logic       irq_done_en = 1'b0;
   logic       tx_pin, buf_empty, tx_done, irq_empty, irq_done;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   uart_tx_dbuf i_uart_tx_dbuf (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .dbl_speed(dbl_speed),
      .divisor(divisor), .wr_valid(wr_valid), .wr_data(wr_data),
      .done_clr(done_clr), .gpo_value(gpo_value), .irq_empty_en(irq_empty_en),
      .irq_done_en(irq_done_en), .tx_pin(tx_pin), .buf_empty(buf_empty),
      .tx_done(tx_done), .irq_empty(irq_empty), .irq_done(irq_done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // n rising edges, then settle on the falling edge
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // ends half a cycle after the capturing edge k
   task automatic do_write(input logic [7:0] d);
      wr_valid = 1'b1;
      wr_data  = d;
      tick(1);
      wr_valid = 1'b0;
   endtask

   // entered at offset 0 of the start bit; leaves right after the stop bit ends
   task automatic run_frame(input logic [7:0] d, input int b, input bit queue,
                            input logic [7:0] qa, input logic [7:0] qc);
      for (int i = 0; i < 10; i++) begin
         logic e;
         e = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : d[i-1];
         if (queue && i == 1) begin
            do_write(qa);
            chk("R5 queued write fills buffer", buf_empty, 1'b0);
            do_write(qc);
            chk("R6 write when full keeps buf_empty", buf_empty, 1'b0);
            chk("R6 write when full keeps tx_done", tx_done, 1'b0);
            tick(b/2 - 2);
         end else begin
            tick(b/2);
         end
         chk($sformatf("R2 bit %0d of %02h", i, d), tx_pin, e);
         tick(b - b/2);
      end
   endtask

   task automatic t_reset;
      irq_empty_en = 1'b1;
      irq_done_en  = 1'b1;
      tick(1);
      chk("R1 reset tx_pin high", tx_pin, 1'b1);
      chk("R1 reset buf_empty", buf_empty, 1'b1);
      chk("R1 reset tx_done", tx_done, 1'b0);
      rst_n = 1'b1;
      tick(3);
      chk("R2 idle line high", tx_pin, 1'b1);
      chk("R11 irq_empty follows flag", irq_empty, 1'b1);
      chk("R11 irq_done follows flag", irq_done, 1'b0);
      irq_empty_en = 1'b0;
      #1 chk("R11 irq_empty masked", irq_empty, 1'b0);
   endtask

   task automatic t_single(input logic [7:0] d, input logic [11:0] dv, input bit dbl);
      int b;
      divisor   = dv;
      dbl_speed = dbl;
      b = (dbl ? 8 : 16) * (int'(dv) + 1);
      do_write(d);
      chk("R5 buf_empty low after write", buf_empty, 1'b0);
      tick(1);
      chk("R5 start bit one edge after write", tx_pin, 1'b0);
      chk("R5 buf_empty back after load", buf_empty, 1'b1);
      run_frame(d, b, 1'b0, 8'h00, 8'h00);
      chk("R8 tx_done set after stop", tx_done, 1'b1);
      chk("R2 line high after frame", tx_pin, 1'b1);
      irq_done_en = 1'b1;
      #1 chk("R11 irq_done with enable", irq_done, 1'b1);
      irq_done_en = 1'b0;
      #1 chk("R11 irq_done masked", irq_done, 1'b0);
      tick(5);
      chk("R8 tx_done stays set", tx_done, 1'b1);
      done_clr = 1'b1;
      tick(1);
      done_clr = 1'b0;
      chk("R9 done_clr clears tx_done", tx_done, 1'b0);
   endtask

   // exact start-bit and stop-bit edges; data bit0 must be 1
   task automatic t_edges(input string tag, input logic [7:0] d,
                          input logic [11:0] dv, input bit dbl);
      int b;
      divisor   = dv;
      dbl_speed = dbl;
      b = (dbl ? 8 : 16) * (int'(dv) + 1);
      do_write(d);
      tick(1);
      tick(b - 1);
      chk({tag, " start bit last cycle"}, tx_pin, 1'b0);
      tick(1);
      chk({tag, " data bit0 at start end"}, tx_pin, d[0]);
      tick(9 * b - 1);
      chk({tag, " stop bit last cycle"}, tx_pin, 1'b1);
      chk("R8 tx_done not yet set", tx_done, 1'b0);
      tick(1);
      chk("R8 tx_done set on stop end", tx_done, 1'b1);
   endtask

   task automatic t_b2b;
      int b;
      divisor   = 12'd1;
      dbl_speed = 1'b0;
      b = 32;
      do_write(8'hA5);
      chk("R9 accepted write clears tx_done", tx_done, 1'b0);
      tick(1);
      run_frame(8'hA5, b, 1'b1, 8'h3C, 8'hFF);
      chk("R7 queued start bit with no gap", tx_pin, 1'b0);
      chk("R7 tx_done low between frames", tx_done, 1'b0);
      chk("R7 buffer freed on reload", buf_empty, 1'b1);
      run_frame(8'h3C, b, 1'b0, 8'h00, 8'h00);
      chk("R8 done after last queued frame", tx_done, 1'b1);
      tick(3 * b);
      chk("R6 ignored byte never sent", tx_pin, 1'b1);
      chk("R6 buffer still empty", buf_empty, 1'b1);
   endtask

   task automatic t_gpo;
      divisor   = 12'd1;
      dbl_speed = 1'b0;
      do_write(8'h00);
      tick(1);
      tx_en     = 1'b0;
      gpo_value = 1'b1;
      #1 chk("R10 gpo high during frame", tx_pin, 1'b1);
      gpo_value = 1'b0;
      #1 chk("R10 gpo low", tx_pin, 1'b0);
      tick(400);
      gpo_value = 1'b1;
      #1 chk("R10 gpo high when idle", tx_pin, 1'b1);
      tx_en = 1'b1;
      #1 chk("R2 pin returns to idle line", tx_pin, 1'b1);
   endtask

   initial begin
      t_reset();
      t_single(8'h4E, 12'd1, 1'b0);
      t_single(8'hB1, 12'd0, 1'b1);
      t_edges("R3", 8'h35, 12'd20, 1'b0);
      t_edges("R4", 8'hC9, 12'd3, 1'b1);
      t_b2b();
      t_gpo();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule